// File: doc/BRIEF.md
# Programmable Lookup-Table Logic Cluster

This block is a cluster of identical programmable logic cells. Each cell holds a 16-entry truth table and a flip-flop. In logic mode the table computes any Boolean function of the cell's four data inputs. In arithmetic mode the cell is one bit of a ripple adder that works out both possible carry paths at the same time. The cells are cascaded through three links: a table-result link, a register link and a pair of carry links. All cells share one clock, one clock enable, one synchronous clear and one synchronous load.

Per-cell configuration bits set the truth table, the mode and the two link selects. They are plain static inputs. The run-time inputs are the four data vectors, the add/subtract control, the cluster carry-select, the two link inputs that feed cell 0, and the load values. Arithmetic runs through the cluster as a carry-select adder. Bit 0 of the lower carry chain is tied to 0 and bit 0 of the upper chain is tied to 1. The single `carry_sel` input picks which precomputed sum every cell shows and which final carry leaves the cluster. The add/subtract control inverts the `in_a` operand, so subtraction is a matter of driving `carry_sel` high at the same time.

Top module: `lab_cluster`

## Requirements
- R1: In logic mode, cell i drives `comb_out[i] = cfg_table[16*i + idx]`, where idx is the 4-bit value {bit3, in_c[i], in_b[i], in_a[i]} with `in_a` as bit 0, and bit3 is `in_d[i]` when `cfg_chain_lut[i]` is 0.
- R2: When `cfg_chain_lut[i]` is 1, bit3 of the table index is taken from the table link, which is `comb_out[i-1]` for cell i, or `lut_chain_in` for cell 0. `lut_chain_out` equals `comb_out[N-1]`.
- R3: When every cell is in arithmetic mode, {`carry_out`, `comb_out`} equals `(in_a ^ {N{addnsub}}) + in_b + carry_sel`, taken over N+1 bits.
- R4: `carry_out0` and `carry_out1` are the final carries of the chain computed with a bit-0 carry of 0 and of 1. `carry_out` equals `carry_out1` when `carry_sel` is 1 and `carry_out0` otherwise. The lower chain's carry never exceeds the upper chain's carry at any cell.
- R5: A cell in logic mode passes both incoming carries on unchanged. When all cells are in logic mode, `carry_out0`=0 and `carry_out1`=1.
- R6: While `rst_n` is low, `reg_out` is all zeros, with no clock needed.
- R7: When `ce` is 0, no register changes at a clock edge, whatever the values of `sclr` and `sload`.
- R8: When `ce` and `sclr` are both 1, every register becomes 0 at the edge. This holds even when `sload` is 1.
- R9: When `ce` and `sload` are 1 and `sclr` is 0, register i takes `load_val[i]`.
- R10: Under `ce` with no clear and no load, register i takes `comb_out[i]` when `cfg_chain_reg[i]` is 0. When `cfg_chain_reg[i]` is 1 it takes the register link instead, which is `reg_out[i-1]`, or `reg_chain_in` for cell 0. `reg_chain_out` equals `reg_out[N-1]`.
- R11: With all cells in arithmetic mode, `addnsub`=1 and `carry_sel`=1, `comb_out` equals `(in_b - in_a) mod 2^N`. `carry_out` is 1 exactly when `in_b >= in_a`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cluster clock |
| rst_n | input | 1 | Asynchronous active-low reset of all registers |
| ce | input | 1 | Shared clock enable |
| sclr | input | 1 | Shared synchronous clear |
| sload | input | 1 | Shared synchronous load |
| load_val | input | N | Per-cell value for synchronous load |
| cfg_table | input | 16*N | Truth tables, 16 bits per cell, cell 0 lowest |
| cfg_arith | input | N | Per-cell mode: 1 arithmetic, 0 logic |
| cfg_chain_reg | input | N | Per-cell register D source: 1 register link |
| cfg_chain_lut | input | N | Per-cell table bit3 source: 1 table link |
| in_a | input | N | Data input a (table bit 0, adder operand inverted by addnsub) |
| in_b | input | N | Data input b (table bit 1, adder operand) |
| in_c | input | N | Data input c (table bit 2) |
| in_d | input | N | Data input d (table bit 3) |
| addnsub | input | 1 | 1 inverts operand a for subtraction |
| carry_sel | input | 1 | Cluster carry-in: picks the carry-1 or carry-0 path |
| lut_chain_in | input | 1 | Table link into cell 0 |
| reg_chain_in | input | 1 | Register link into cell 0 |
| comb_out | output | N | Combinational cell results |
| reg_out | output | N | Registered cell results |
| lut_chain_out | output | 1 | Table link out of the last cell |
| reg_chain_out | output | 1 | Register link out of the last cell |
| carry_out0 | output | 1 | Final carry of the carry-0 path |
| carry_out1 | output | 1 | Final carry of the carry-1 path |
| carry_out | output | 1 | Final carry of the selected path |

## Verification
The logic function is tried with random truth tables and random data, first with the table link off and then with it on. Agreement in the first case shows the index bit order is right. Agreement in the second shows that bit3 follows the previous cell, so the link order is right. The adder is driven with all-ones plus one, and with a subtraction on each side of zero. These patterns separate the two carry paths, the final selection and the inversion of operand a. Directed steps with clear and load raised together, and with the enable low, expose the control priority. A long random phase then mixes the modes and links from cell to cell.

// File: rtl/le_pkg.sv
package le_pkg;
  parameter int LUT_INPUTS = 4;
  localparam int LUT_SIZE = 1 << LUT_INPUTS;

  typedef enum logic {
    CELL_LOGIC = 1'b0,
    CELL_ARITH = 1'b1
  } cell_mode_e;

  typedef struct packed {
    logic ce;
    logic sclr;
    logic sload;
  } reg_ctrl_t;
endpackage

// File: rtl/le_lut.sv
module le_lut #(
  parameter int K = le_pkg::LUT_INPUTS,
  localparam int SIZE = 1 << K
) (
  input  logic [SIZE-1:0] table_bits,
  input  logic [K-1:0]    sel,
  output logic            y
);
  // Binary mux tree: level 0 holds the table, each level halves it.
  logic [SIZE-1:0] lvl [K+1];

  assign lvl[0] = table_bits;

  for (genvar l = 0; l < K; l++) begin : g_level
    localparam int W = SIZE >> (l + 1);
    for (genvar j = 0; j < SIZE; j++) begin : g_node
      if (j < W) begin : g_mux
        assign lvl[l+1][j] = sel[l] ? lvl[l][2*j+1] : lvl[l][2*j];
      end else begin : g_pad
        assign lvl[l+1][j] = 1'b0;
      end
    end
  end

  assign y = lvl[K][0];
endmodule

// File: rtl/le_arith.sv
module le_arith (
  input  logic a_raw,
  input  logic b,
  input  logic invert,
  input  logic cin0,
  input  logic cin1,
  input  logic pick_hi,
  output logic sum,
  output logic cout0,
  output logic cout1
);
  logic a, prop, gen;

  assign a     = a_raw ^ invert;
  assign prop  = a ^ b;
  assign gen   = a & b;
  assign cout0 = gen | (prop & cin0);
  assign cout1 = gen | (prop & cin1);
  assign sum   = pick_hi ? (prop ^ cin1) : (prop ^ cin0);
endmodule

// File: rtl/le_reg.sv
module le_reg
  import le_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  reg_ctrl_t ctrl,
  input  logic      load_val,
  input  logic      d,
  output logic      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (ctrl.ce) begin
      if (ctrl.sclr)       q <= 1'b0;
      else if (ctrl.sload) q <= load_val;
      else                 q <= d;
    end
  end

  // R8
  reg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ce && ctrl.sclr) |=> (q == 1'b0));

  // R9
  reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.ce && !ctrl.sclr && ctrl.sload) |=> (q == $past(load_val)));

  // R7
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.ce |=> $stable(q));
endmodule

// File: rtl/le_cell.sv
module le_cell
  import le_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  reg_ctrl_t           ctrl,
  input  logic                load_val,
  input  logic [LUT_SIZE-1:0] table_bits,
  input  logic                arith_en,
  input  logic                chain_reg_sel,
  input  logic                chain_lut_sel,
  input  logic                in_a,
  input  logic                in_b,
  input  logic                in_c,
  input  logic                in_d,
  input  logic                addnsub,
  input  logic                carry_sel,
  input  logic                cin0,
  input  logic                cin1,
  input  logic                lut_link_in,
  input  logic                reg_link_in,
  output logic                result,
  output logic                q,
  output logic                cout0,
  output logic                cout1
);
  cell_mode_e mode;
  logic [LUT_INPUTS-1:0] idx;
  logic lut_y, sum, ac0, ac1, d_next;

  assign mode = cell_mode_e'(arith_en);
  assign idx  = {(chain_lut_sel ? lut_link_in : in_d), in_c, in_b, in_a};

  le_lut #(.K(LUT_INPUTS)) u_lut (
    .table_bits(table_bits),
    .sel       (idx),
    .y         (lut_y)
  );

  le_arith u_arith (
    .a_raw  (in_a),
    .b      (in_b),
    .invert (addnsub),
    .cin0   (cin0),
    .cin1   (cin1),
    .pick_hi(carry_sel),
    .sum    (sum),
    .cout0  (ac0),
    .cout1  (ac1)
  );

  always_comb begin
    if (mode == CELL_ARITH) begin
      result = sum;
      cout0  = ac0;
      cout1  = ac1;
    end else begin
      result = lut_y;
      cout0  = cin0;
      cout1  = cin1;
    end
  end

  assign d_next = chain_reg_sel ? reg_link_in : result;

  le_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .load_val(load_val),
    .d       (d_next),
    .q       (q)
  );

  // R4
  carry_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cin0 || cin1) |-> (!cout0 || cout1));
endmodule

// File: rtl/lab_cluster.sv
module lab_cluster
  import le_pkg::*;
#(
  parameter int N_CELLS = 10,
  localparam int TW = N_CELLS * LUT_SIZE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               sclr,
  input  logic               sload,
  input  logic [N_CELLS-1:0] load_val,
  input  logic [TW-1:0]      cfg_table,
  input  logic [N_CELLS-1:0] cfg_arith,
  input  logic [N_CELLS-1:0] cfg_chain_reg,
  input  logic [N_CELLS-1:0] cfg_chain_lut,
  input  logic [N_CELLS-1:0] in_a,
  input  logic [N_CELLS-1:0] in_b,
  input  logic [N_CELLS-1:0] in_c,
  input  logic [N_CELLS-1:0] in_d,
  input  logic               addnsub,
  input  logic               carry_sel,
  input  logic               lut_chain_in,
  input  logic               reg_chain_in,
  output logic [N_CELLS-1:0] comb_out,
  output logic [N_CELLS-1:0] reg_out,
  output logic               lut_chain_out,
  output logic               reg_chain_out,
  output logic               carry_out0,
  output logic               carry_out1,
  output logic               carry_out
);
  reg_ctrl_t ctrl;
  logic [N_CELLS:0] c0_link, c1_link, lut_link, reg_link;

  assign ctrl        = '{ce: ce, sclr: sclr, sload: sload};
  assign c0_link[0]  = 1'b0;
  assign c1_link[0]  = 1'b1;
  assign lut_link[0] = lut_chain_in;
  assign reg_link[0] = reg_chain_in;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    le_cell u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl         (ctrl),
      .load_val     (load_val[i]),
      .table_bits   (cfg_table[i*LUT_SIZE +: LUT_SIZE]),
      .arith_en     (cfg_arith[i]),
      .chain_reg_sel(cfg_chain_reg[i]),
      .chain_lut_sel(cfg_chain_lut[i]),
      .in_a         (in_a[i]),
      .in_b         (in_b[i]),
      .in_c         (in_c[i]),
      .in_d         (in_d[i]),
      .addnsub      (addnsub),
      .carry_sel    (carry_sel),
      .cin0         (c0_link[i]),
      .cin1         (c1_link[i]),
      .lut_link_in  (lut_link[i]),
      .reg_link_in  (reg_link[i]),
      .result       (comb_out[i]),
      .q            (reg_out[i]),
      .cout0        (c0_link[i+1]),
      .cout1        (c1_link[i+1])
    );
    assign lut_link[i+1] = comb_out[i];
    assign reg_link[i+1] = reg_out[i];
  end

  assign lut_chain_out = lut_link[N_CELLS];
  assign reg_chain_out = reg_link[N_CELLS];
  assign carry_out0    = c0_link[N_CELLS];
  assign carry_out1    = c1_link[N_CELLS];
  assign carry_out     = carry_sel ? carry_out1 : carry_out0;

  // R3
  arith_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&cfg_arith) |-> ({carry_out, comb_out} ==
      ({1'b0, in_a ^ {N_CELLS{addnsub}}} + {1'b0, in_b} + {{N_CELLS{1'b0}}, carry_sel})));

  // R11
  sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cfg_arith) && addnsub && carry_sel) |-> (carry_out == (in_b >= in_a)));
endmodule

// File: tb/tb_lab_cluster.sv
module tb_lab_cluster;
  localparam int N = 10;
  localparam int LS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0, sclr = 1'b0, sload = 1'b0;
  logic [N-1:0] load_val = '0;
  logic [N*LS-1:0] cfg_table = '0;
  logic [N-1:0] cfg_arith = '0, cfg_chain_reg = '0, cfg_chain_lut = '0;
  logic [N-1:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic addnsub = 1'b0, carry_sel = 1'b0, lut_chain_in = 1'b0, reg_chain_in = 1'b0;
  logic [N-1:0] comb_out, reg_out;
  logic lut_chain_out, reg_chain_out, carry_out0, carry_out1, carry_out;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] exp_comb, exp_q, exp_qn;
  logic exp_c0, exp_c1;

  always #5 clk = ~clk;

  lab_cluster #(.N_CELLS(N)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclr(sclr), .sload(sload),
    .load_val(load_val), .cfg_table(cfg_table), .cfg_arith(cfg_arith),
    .cfg_chain_reg(cfg_chain_reg), .cfg_chain_lut(cfg_chain_lut),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_d(in_d),
    .addnsub(addnsub), .carry_sel(carry_sel),
    .lut_chain_in(lut_chain_in), .reg_chain_in(reg_chain_in),
    .comb_out(comb_out), .reg_out(reg_out),
    .lut_chain_out(lut_chain_out), .reg_chain_out(reg_chain_out),
    .carry_out0(carry_out0), .carry_out1(carry_out1), .carry_out(carry_out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model taken from the requirements.
  task automatic model_eval();
    logic c0, c1, prev_lut, a, b, p, bit3;
    int idx;
    c0 = 1'b0; c1 = 1'b1; prev_lut = lut_chain_in;
    for (int i = 0; i < N; i++) begin
      if (cfg_arith[i]) begin
        a = in_a[i] ^ addnsub; b = in_b[i]; p = a ^ b;
        exp_comb[i] = p ^ (carry_sel ? c1 : c0);
        c0 = (a & b) | (p & c0);
        c1 = (a & b) | (p & c1);
      end else begin
        bit3 = cfg_chain_lut[i] ? prev_lut : in_d[i];
        idx = {bit3, in_c[i], in_b[i], in_a[i]};
        exp_comb[i] = cfg_table[i*LS + idx];
      end
      prev_lut = exp_comb[i];
    end
    exp_c0 = c0; exp_c1 = c1;
    for (int i = 0; i < N; i++) begin
      if (!ce)        exp_qn[i] = exp_q[i];
      else if (sclr)  exp_qn[i] = 1'b0;
      else if (sload) exp_qn[i] = load_val[i];
      else if (cfg_chain_reg[i]) exp_qn[i] = (i == 0) ? reg_chain_in : exp_q[i-1];
      else            exp_qn[i] = exp_comb[i];
    end
  endtask

  // Called just after a falling edge with inputs already set.
  task automatic step(input string ctag, input string rtag);
    model_eval();
    #1;
    chk(comb_out == exp_comb, ctag, 64'(comb_out), 64'(exp_comb));
    chk({carry_out0, carry_out1} == {exp_c0, exp_c1}, "R4", 64'({carry_out0, carry_out1}), 64'({exp_c0, exp_c1}));
    chk(carry_out == (carry_sel ? exp_c1 : exp_c0), "R4", 64'(carry_out), 64'(carry_sel ? exp_c1 : exp_c0));
    chk(lut_chain_out == exp_comb[N-1], "R2", 64'(lut_chain_out), 64'(exp_comb[N-1]));
    @(posedge clk);
    @(negedge clk);
    exp_q = exp_qn;
    chk(reg_out == exp_q, rtag, 64'(reg_out), 64'(exp_q));
    chk(reg_chain_out == exp_q[N-1], "R10", 64'(reg_chain_out), 64'(exp_q[N-1]));
  endtask

  function automatic logic [N*LS-1:0] rand_tables();
    logic [N*LS-1:0] t;
    for (int i = 0; i < N; i++) t[i*LS +: LS] = LS'($urandom);
    return t;
  endfunction

  task automatic rand_data();
    in_a = N'($urandom); in_b = N'($urandom); in_c = N'($urandom); in_d = N'($urandom);
    load_val = N'($urandom); lut_chain_in = 1'($urandom); reg_chain_in = 1'($urandom);
    carry_sel = 1'($urandom); addnsub = 1'($urandom);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_q = '0;
    @(negedge clk);
    #1;
    // R6: reset state
    chk(reg_out == '0, "R6", 64'(reg_out), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 and R5: logic mode with random tables, links off
    cfg_table = rand_tables();
    ce = 1'b1;
    for (int k = 0; k < 20; k++) begin
      rand_data();
      step("R1", "R10");
      chk(carry_out0 == 1'b0 && carry_out1 == 1'b1, "R5", 64'({carry_out0, carry_out1}), 64'b01);
    end

    // R2: table link on in every cell
    cfg_chain_lut = '1;
    for (int k = 0; k < 20; k++) begin
      cfg_table = rand_tables();
      rand_data();
      step("R2", "R10");
    end
    cfg_chain_lut = '0;

    // R3: all ones plus one, carry-0 path
    cfg_arith = '1;
    in_a = '1; in_b = N'(1); addnsub = 1'b0; carry_sel = 1'b0;
    step("R3", "R10");
    chk(comb_out == '0 && carry_out == 1'b1, "R3", 64'({carry_out, comb_out}), 64'h400);
    // R4: same operands, carry-1 path
    carry_sel = 1'b1;
    step("R4", "R10");
    chk(comb_out == N'(1) && carry_out1 == 1'b1, "R4", 64'({carry_out1, comb_out}), 64'h401);

    // R11: subtraction on both sides of zero
    addnsub = 1'b1; carry_sel = 1'b1; in_b = N'(5); in_a = N'(7);
    step("R11", "R10");
    chk(comb_out == N'(10'h3FE) && carry_out == 1'b0, "R11", 64'({carry_out, comb_out}), 64'h3FE);
    in_b = N'(7); in_a = N'(5);
    step("R11", "R10");
    chk(comb_out == N'(2) && carry_out == 1'b1, "R11", 64'({carry_out, comb_out}), 64'h402);

    // R8: clear beats load
    cfg_arith = '0;
    load_val = '1; sload = 1'b1; sclr = 1'b1;
    step("R1", "R8");
    // R9: load
    sclr = 1'b0; load_val = N'(10'h2A5);
    step("R1", "R9");
    chk(reg_out == N'(10'h2A5), "R9", 64'(reg_out), 64'h2A5);
    // R7: enable low blocks clear and load
    ce = 1'b0; sclr = 1'b1; load_val = '0;
    step("R1", "R7");
    chk(reg_out == N'(10'h2A5), "R7", 64'(reg_out), 64'h2A5);
    ce = 1'b1; sclr = 1'b0; sload = 1'b0;

    // R10: register link shift
    cfg_chain_reg = '1;
    for (int k = 0; k < 12; k++) begin
      reg_chain_in = (k % 3 == 0);
      step("R1", "R10");
    end
    cfg_chain_reg = '0;

    // R6: asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    exp_q = '0;
    chk(reg_out == '0, "R6", 64'(reg_out), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Random mixed phase
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0) begin
        cfg_table = rand_tables();
        cfg_arith = ($urandom % 3 == 0) ? '1 : N'($urandom);
        cfg_chain_reg = N'($urandom);
        cfg_chain_lut = N'($urandom);
      end
      rand_data();
      ce = ($urandom % 5) != 0;
      sclr = ($urandom % 9) == 0;
      sload = ($urandom % 7) == 0;
      step(cfg_arith == '1 ? "R3" : "R1", "R10");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule